// File: doc/BRIEF.md
# External Memory Bus Front End (Separate or Multiplexed)

This block turns single requests from an internal CPU-side port into cycles on an external memory bus. The address can be up to 20 bits wide and the data up to 16 bits. A two-bit mode field chooses between two bus styles. In the separate style, address and data have their own pins. In the multiplexed style, some address pins also carry the data byte after an address latch enable pulse. A width input chooses an 8-bit or a 16-bit data bus.

Every pin is modelled as a triple: an output value, an output enable and an input. The block drives the address pins, the data pins, the address latch enable, an active-low read strobe and two active-low write strobes. It also reports, from the live mode and width inputs, which data pins are free for general-purpose I/O.

The request port uses a valid/ready handshake. The mode, the width and the request fields are latched when a request is accepted. A one-clock `done` pulse returns the read data or an error flag.

The controller is a state machine with these states:
- `ST_IDLE`: ready for a request.
- `ST_SEP_STB` and `ST_SEP_END`: the two clocks of a separate-bus cycle.
- `ST_MUX_ADR`, `ST_MUX_DAT` and `ST_MUX_END`: the three clocks of a multiplexed cycle.
- `ST_REJECT`: a one-clock error response.

From `ST_IDLE`, an accepted request goes to one of three states:
- `ST_REJECT`, for an odd address on a 16-bit multiplexed bus.
- `ST_MUX_ADR`, for any other multiplexed request.
- `ST_SEP_STB`, for a separate-bus request.

The other transitions are fixed:
- `ST_SEP_STB` → `ST_SEP_END` → `ST_IDLE`
- `ST_MUX_ADR` → `ST_MUX_DAT` → `ST_MUX_END` → `ST_IDLE`
- `ST_REJECT` → `ST_IDLE`

Top module: `xbus_bridge`

## Requirements
- R1: `mode_sel` values 2'b01 and 2'b10 select the multiplexed bus, and 2'b00 and 2'b11 select the separate bus. `bus8`=1 selects an 8-bit data bus and `bus8`=0 a 16-bit one. Both inputs, and every request field, are sampled only at the clock edge where a request is accepted, and they hold for the whole cycle.
- R2: `req_ready` is high only when the block is idle. A request is accepted at a rising edge where `req_valid` and `req_ready` are both high. `done` is a pulse one clock long.
- R3: A separate-bus cycle lasts two clocks after acceptance. In the first clock the strobe is low. In the second the strobe is high and `done` is high. During both clocks the full request address is driven on `addr_o`, with every bit of `addr_oe` high.
- R4: On a separate bus, a 16-bit write drives all of `data_o` with the write data, and an 8-bit write drives only bits 7:0. Reads leave `data_oe` at zero. Read data is captured from `data_i`; in 8-bit mode it is zero-extended from bits 7:0.
- R5: A multiplexed cycle lasts three clocks after acceptance. In the first, `ale_o` is high for one clock and the full address is driven on all address pins. In the second, `ale_o` is low and the strobe is low. In the third, the strobe is high and `done` is high.
- R6: On an 8-bit multiplexed bus, data bits 7:0 share address pins 7:0. On a 16-bit multiplexed bus they share address pins 8:1, and pin 0 stays a pure address pin. In the data clocks of a write the shared pins carry the write byte and the other address pins keep the address. The data pins are never driven in multiplexed mode.
- R7: In a multiplexed read the shared pins are undriven in both data clocks. The read byte is taken from the shared pins of `addr_i` at the edge that ends the read strobe clock, and is returned zero-extended.
- R8: A request to an odd address on a 16-bit multiplexed bus is rejected. One clock after acceptance, `done` and `err` are both high. No strobe or `ale_o` is asserted and no pin is driven.
- R9: On a 16-bit separate bus, `wr_lo_n_o` and `wr_hi_n_o` are low in the strobe clock exactly when `req_be[0]` and `req_be[1]` are set. In every other configuration `wr_lo_n_o` is the single write strobe and `wr_hi_n_o` (byte-high enable) stays high. A read strobe never overlaps a write strobe.
- R10: `gpio_free` reflects the live `mode_sel` and `bus8` inputs as follows:
  - 8-bit separate bus: bits 15:8 are high.
  - 16-bit separate bus: all bits are zero.
  - multiplexed bus: all bits are high.
- R11: While the block is idle and after reset, no output enable is high, both strobes are high and `ale_o` is low. `err` is low on every cycle that is not rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Bus style select (R1) |
| bus8 | input | 1 | 1 = 8-bit data bus, 0 = 16-bit |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | High when idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_be | input | 2 | Byte enables for the 16-bit separate bus |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Rejected request, valid with done |
| rdata | output | DW | Read data, valid with done on reads |
| addr_o | output | AW | Address pin output values |
| addr_oe | output | AW | Address pin output enables |
| addr_i | input | AW | Address pin input values (shared data in multiplexed mode) |
| data_o | output | DW | Data pin output values |
| data_oe | output | DW | Data pin output enables |
| data_i | input | DW | Data pin input values |
| ale_o | output | 1 | Address latch enable, active high |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_lo_n_o | output | 1 | Low-byte write strobe, or single write strobe |
| wr_hi_n_o | output | 1 | High-byte write strobe, or byte-high enable |
| gpio_free | output | DW | Data pins released for general I/O |

## Verification
The bench builds the block with the defaults AW=20 and DW=16. This exposes the full mix of pins:
- the shared window on pins 7:0 or 8:1, beside untouched high address bits up to bit 19;
- an upper data byte that either carries data or is released;
- a 16-bit multiplexed bus whose pin 0 stays address-only, so odd addresses can be rejected.

A bus model in the bench answers reads with an address-derived word. In multiplexed mode it answers using the address it latched on ALE. Between strobes it drives garbage, so a capture on the wrong edge shows up as a wrong value.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEP_STB,
        ST_SEP_END,
        ST_MUX_ADR,
        ST_MUX_DAT,
        ST_MUX_END,
        ST_REJECT
    } xb_state_e;

    typedef enum logic [1:0] {
        LAY_SEP16 = 2'd0,
        LAY_SEP8  = 2'd1,
        LAY_MUX16 = 2'd2,
        LAY_MUX8  = 2'd3
    } xb_layout_e;

    // Bus style is multiplexed when exactly one mode bit is set.
    function automatic xb_layout_e xb_decode(input logic [1:0] mode, input logic narrow);
        logic muxed;
        muxed = mode[1] ^ mode[0];
        unique case ({muxed, narrow})
            2'b00:   return LAY_SEP16;
            2'b01:   return LAY_SEP8;
            2'b10:   return LAY_MUX16;
            default: return LAY_MUX8;
        endcase
    endfunction

    function automatic logic xb_is_mux(input xb_layout_e lay);
        return (lay == LAY_MUX8) || (lay == LAY_MUX16);
    endfunction

endpackage

// File: rtl/xbus_cfg.sv
`timescale 1ns/1ps
module xbus_cfg
    import xbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [1:0]    mode_sel,
    input  logic          bus8,
    output xb_layout_e    layout,
    output logic [DW-1:0] gpio_free
);
    localparam int HW = DW / 2;
    localparam logic [DW-1:0] UPPER_BYTE = {{(DW-HW){1'b1}}, {HW{1'b0}}};

    always_comb begin
        layout = xb_decode(mode_sel, bus8);
        unique case (layout)
            LAY_SEP16: gpio_free = '0;
            LAY_SEP8:  gpio_free = UPPER_BYTE;
            default:   gpio_free = '1;
        endcase
    end
endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
module xbus_seq
    import xbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_odd,
    input  xb_layout_e cfg_layout,
    output logic       req_ready,
    output logic       accept,
    output xb_layout_e lay_q,
    output logic       write_q,
    output logic       bus_on,
    output logic       ale,
    output logic       strobe,
    output logic       data_phase,
    output logic       capture,
    output logic       done,
    output logic       err
);
    xb_state_e state, state_nx;

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (cfg_layout == LAY_MUX16 && req_odd)
                        state_nx = ST_REJECT;
                    else if (xb_is_mux(cfg_layout))
                        state_nx = ST_MUX_ADR;
                    else
                        state_nx = ST_SEP_STB;
                end
            end
            ST_SEP_STB: state_nx = ST_SEP_END;
            ST_SEP_END: state_nx = ST_IDLE;
            ST_MUX_ADR: state_nx = ST_MUX_DAT;
            ST_MUX_DAT: state_nx = ST_MUX_END;
            ST_MUX_END: state_nx = ST_IDLE;
            ST_REJECT:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register with the per-cycle configuration latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lay_q   <= LAY_SEP16;
            write_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                lay_q   <= cfg_layout;
                write_q <= req_write;
            end
        end
    end

    // phase outputs
    always_comb begin
        req_ready  = 1'b0;
        bus_on     = 1'b0;
        ale        = 1'b0;
        strobe     = 1'b0;
        data_phase = 1'b0;
        done       = 1'b0;
        err        = 1'b0;
        unique case (state)
            ST_IDLE:    req_ready = 1'b1;
            ST_SEP_STB: begin bus_on = 1'b1; strobe = 1'b1; data_phase = 1'b1; end
            ST_SEP_END: begin bus_on = 1'b1; data_phase = 1'b1; done = 1'b1; end
            ST_MUX_ADR: begin bus_on = 1'b1; ale = 1'b1; end
            ST_MUX_DAT: begin bus_on = 1'b1; strobe = 1'b1; data_phase = 1'b1; end
            ST_MUX_END: begin bus_on = 1'b1; data_phase = 1'b1; done = 1'b1; end
            ST_REJECT:  begin done = 1'b1; err = 1'b1; end
            default:    req_ready = 1'b0;
        endcase
        accept  = req_valid && req_ready;
        capture = strobe && !write_q;
    end
endmodule

// File: rtl/xbus_lane.sv
`timescale 1ns/1ps
module xbus_lane
    import xbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_be,
    input  xb_layout_e    lay,
    input  logic          write_q,
    input  logic          bus_on,
    input  logic          ale,
    input  logic          strobe,
    input  logic          data_phase,
    input  logic          capture,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] addr_oe,
    input  logic [AW-1:0] addr_i,
    output logic [DW-1:0] data_o,
    output logic [DW-1:0] data_oe,
    input  logic [DW-1:0] data_i,
    output logic          ale_o,
    output logic          rd_n_o,
    output logic          wr_lo_n_o,
    output logic          wr_hi_n_o,
    output logic [DW-1:0] rdata
);
    localparam int HW = DW / 2;
    localparam logic [DW-1:0] LOW_BYTE = {{(DW-HW){1'b0}}, {HW{1'b1}}};

    function automatic logic [AW-1:0] share_mask(input int base);
        logic [AW-1:0] m;
        for (int i = 0; i < AW; i++)
            m[i] = (i >= base) && (i < base + HW);
        return m;
    endfunction

    localparam logic [AW-1:0] SH8  = share_mask(0);
    localparam logic [AW-1:0] SH16 = share_mask(1);

    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [1:0]    be_q;
    logic [AW-1:0] sh;
    logic [AW-1:0] wsh;
    logic          split;
    logic          muxed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    always_comb begin
        muxed = xb_is_mux(lay);
        split = (lay == LAY_SEP16);
        unique case (lay)
            LAY_MUX8:  sh = SH8;
            LAY_MUX16: sh = SH16;
            default:   sh = '0;
        endcase
        wsh = AW'(wdata_q[HW-1:0]);
        if (lay == LAY_MUX16)
            wsh = wsh << 1;

        // address pins, shared window carries data after ALE
        addr_o = ale ? addr_q : ((addr_q & ~sh) | (wsh & sh));
        if (!bus_on)
            addr_oe = '0;
        else if (ale || write_q)
            addr_oe = '1;
        else
            addr_oe = ~sh;

        // dedicated data pins, separate bus writes only
        data_o = wdata_q;
        if (bus_on && data_phase && write_q && !muxed)
            data_oe = split ? '1 : LOW_BYTE;
        else
            data_oe = '0;

        ale_o     = ale;
        rd_n_o    = !(strobe && !write_q);
        wr_lo_n_o = !(strobe && write_q && (!split || be_q[0]));
        wr_hi_n_o = !(strobe && write_q && split && be_q[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            unique case (lay)
                LAY_SEP16: rdata <= data_i;
                LAY_SEP8:  rdata <= {{(DW-HW){1'b0}}, data_i[HW-1:0]};
                LAY_MUX8:  rdata <= {{(DW-HW){1'b0}}, addr_i[HW-1:0]};
                default:   rdata <= {{(DW-HW){1'b0}}, addr_i[HW:1]};
            endcase
        end
    end
endmodule

// File: rtl/xbus_bridge.sv
`timescale 1ns/1ps
module xbus_bridge
    import xbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic          bus8,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_be,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] addr_oe,
    input  logic [AW-1:0] addr_i,
    output logic [DW-1:0] data_o,
    output logic [DW-1:0] data_oe,
    input  logic [DW-1:0] data_i,
    output logic          ale_o,
    output logic          rd_n_o,
    output logic          wr_lo_n_o,
    output logic          wr_hi_n_o,
    output logic [DW-1:0] gpio_free
);
    xb_layout_e cfg_layout;
    xb_layout_e lay_q;
    logic accept, write_q, bus_on, ale, strobe, data_phase, capture;

    xbus_cfg #(.DW(DW)) u_cfg (
        .mode_sel  (mode_sel),
        .bus8      (bus8),
        .layout    (cfg_layout),
        .gpio_free (gpio_free)
    );

    xbus_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_odd    (req_addr[0]),
        .cfg_layout (cfg_layout),
        .req_ready  (req_ready),
        .accept     (accept),
        .lay_q      (lay_q),
        .write_q    (write_q),
        .bus_on     (bus_on),
        .ale        (ale),
        .strobe     (strobe),
        .data_phase (data_phase),
        .capture    (capture),
        .done       (done),
        .err        (err)
    );

    xbus_lane #(.AW(AW), .DW(DW)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .lay        (lay_q),
        .write_q    (write_q),
        .bus_on     (bus_on),
        .ale        (ale),
        .strobe     (strobe),
        .data_phase (data_phase),
        .capture    (capture),
        .addr_o     (addr_o),
        .addr_oe    (addr_oe),
        .addr_i     (addr_i),
        .data_o     (data_o),
        .data_oe    (data_oe),
        .data_i     (data_i),
        .ale_o      (ale_o),
        .rd_n_o     (rd_n_o),
        .wr_lo_n_o  (wr_lo_n_o),
        .wr_hi_n_o  (wr_hi_n_o),
        .rdata      (rdata)
    );
endmodule

// File: rtl/xbus_bridge_chk.sv
`timescale 1ns/1ps
module xbus_bridge_chk #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          done,
    input logic          err,
    input logic          ale_o,
    input logic          rd_n_o,
    input logic          wr_lo_n_o,
    input logic          wr_hi_n_o,
    input logic [AW-1:0] addr_oe,
    input logic [DW-1:0] data_oe
);
    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);

    // R7
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |=> rd_n_o);

    // R4
    rd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> (data_oe == '0));

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R9
    no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> (wr_lo_n_o && wr_hi_n_o));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (addr_oe == '0 && data_oe == '0 && rd_n_o && wr_lo_n_o && wr_hi_n_o && !ale_o));
endmodule

bind xbus_bridge xbus_bridge_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/xbus_bridge_test.sv
`timescale 1ns/1ps
module xbus_bridge_test;
    localparam int AW = 20;
    localparam int DW = 16;
    // bench-side layout codes
    localparam int L_S16 = 0, L_S8 = 1, L_M16 = 2, L_M8 = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic bus8 = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0] req_be = 2'b00;
    logic done, err;
    logic [DW-1:0] rdata;
    logic [AW-1:0] addr_o, addr_oe, addr_i;
    logic [DW-1:0] data_o, data_oe, data_i;
    logic ale_o, rd_n_o, wr_lo_n_o, wr_hi_n_o;
    logic [DW-1:0] gpio_free;

    int total = 0;
    int bad = 0;
    int cur_lay = L_S16;
    logic [AW-1:0] lat_a = '0;
    logic [DW-1:0] mw;

    always #10 clk = ~clk;

    xbus_bridge #(.AW(AW), .DW(DW)) uut (.*);

    function automatic logic [DW-1:0] dev_word(input logic [AW-1:0] a);
        return {a[7:0] ^ a[19:12], a[15:8] ^ 8'h3C};
    endfunction

    // external device model
    always @(negedge clk) if (ale_o) lat_a <= addr_o;

    always_comb begin
        data_i = rd_n_o ? 16'hA5A5 : dev_word(addr_o);
        addr_i = ~addr_o;
        mw = dev_word(lat_a);
        if (!rd_n_o && cur_lay == L_M8)  addr_i[7:0] = mw[7:0];
        if (!rd_n_o && cur_lay == L_M16) addr_i[8:1] = mw[7:0];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input logic [1:0] mode, input logic narrow, input logic wr,
                           input logic [AW-1:0] a, input logic [DW-1:0] wd, input logic [1:0] be);
        int l, lat, done_cyc, ale_n, ale_cyc, rd_n, rd_cyc, lo_n, hi_n, drv_n, wchk;
        logic muxed, odd, split, got_err;
        logic [DW-1:0] got_rd, exp_rd;
        logic [AW-1:0] shm;
        muxed = mode[1] ^ mode[0];
        l = muxed ? (narrow ? L_M8 : L_M16) : (narrow ? L_S8 : L_S16);
        odd = (l == L_M16) && a[0];
        split = (l == L_S16);
        lat = odd ? 1 : (muxed ? 3 : 2);
        shm = (l == L_M8) ? 20'h000FF : (l == L_M16) ? 20'h001FE : 20'h0;
        done_cyc = 0; ale_n = 0; ale_cyc = 0; rd_n = 0; rd_cyc = 0;
        lo_n = 0; hi_n = 0; drv_n = 0; wchk = 0; got_err = 0; got_rd = '0;
        @(negedge clk);
        mode_sel = mode; bus8 = narrow; req_write = wr; req_addr = a;
        req_wdata = wd; req_be = be; req_valid = 1'b1; cur_lay = l;
        chk(req_ready == 1'b1, "R2 ready when idle", 32'(req_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // R1: config changes after acceptance must not matter
        mode_sel = 2'($urandom()); bus8 = 1'($urandom());
        req_addr = AW'($urandom()); req_wdata = DW'($urandom()); req_be = 2'($urandom());
        for (int cyc = 1; cyc <= 6; cyc++) begin
            if (req_ready) chk(1'b0, "R2 ready while busy", 32'(cyc), 32'd0);
            if (addr_oe != '0 || data_oe != '0) drv_n++;
            if (muxed && data_oe != '0) chk(1'b0, "R6 data pins driven in mux", 32'(data_oe), 32'd0);
            if (!muxed && !odd && cyc <= lat)
                chk(addr_o == a && addr_oe == '1, "R3 address held", 32'(addr_o), 32'(a));
            if (ale_o) begin
                ale_n++; ale_cyc = cyc;
                chk(addr_o == a && addr_oe == '1, "R5 address at ALE", 32'(addr_o), 32'(a));
            end
            if (muxed && !wr && cyc >= 2 && cyc <= 3)
                chk((addr_oe & shm) == '0, "R7 shared pins undriven", 32'(addr_oe), 32'(~shm & addr_oe));
            if (!rd_n_o) begin
                rd_n++; rd_cyc = cyc;
            end
            if (!wr_lo_n_o) lo_n++;
            if (!wr_hi_n_o) hi_n++;
            if (!wr_lo_n_o || !wr_hi_n_o) begin
                wchk++;
                case (l)
                    L_S16: chk(data_o == wd && data_oe == 16'hFFFF, "R4 16-bit write lanes", 32'(data_o), 32'(wd));
                    L_S8:  chk(data_o[7:0] == wd[7:0] && data_oe == 16'h00FF, "R4 8-bit write lanes", 32'(data_oe), 32'h00FF);
                    L_M8:  chk(addr_o[7:0] == wd[7:0] && addr_o[19:8] == a[19:8] && addr_oe == '1,
                               "R6 8-bit shared write", 32'(addr_o), 32'({a[19:8], wd[7:0]}));
                    default: chk(addr_o[8:1] == wd[7:0] && addr_o[0] == 1'b0 && addr_o[19:9] == a[19:9] && addr_oe == '1,
                               "R6 16-bit shared write", 32'(addr_o), 32'({a[19:9], wd[7:0], 1'b0}));
                endcase
            end
            if (done) begin
                done_cyc = cyc; got_err = err; got_rd = rdata;
                break;
            end
            @(negedge clk);
        end
        if (odd) chk(done_cyc == lat, "R8 reject latency", 32'(done_cyc), 32'(lat));
        else if (muxed) chk(done_cyc == lat, "R5 mux latency", 32'(done_cyc), 32'(lat));
        else chk(done_cyc == lat, "R3 separate latency", 32'(done_cyc), 32'(lat));
        if (odd) begin
            chk(got_err == 1'b1, "R8 error flag", 32'(got_err), 32'd1);
            chk(ale_n + rd_n + lo_n + hi_n + drv_n == 0, "R8 no bus activity", 32'(ale_n + rd_n + lo_n + hi_n + drv_n), 32'd0);
        end else begin
            chk(got_err == 1'b0, "R11 no error", 32'(got_err), 32'd0);
            chk(ale_n == (muxed ? 1 : 0) && (!muxed || ale_cyc == 1), "R5 ALE count", 32'(ale_n), 32'(muxed));
            if (!wr) begin
                exp_rd = (l == L_S16) ? dev_word(a) : {8'h00, dev_word(a) & 16'h00FF};
                chk(rd_n == 1 && rd_cyc == (muxed ? 2 : 1), "R3 read strobe timing", 32'(rd_cyc), 32'(muxed ? 2 : 1));
                chk(lo_n + hi_n == 0, "R9 no write strobe on read", 32'(lo_n + hi_n), 32'd0);
                chk(got_rd == exp_rd, muxed ? "R7 mux read data" : "R4 separate read data", 32'(got_rd), 32'(exp_rd));
            end else begin
                chk(rd_n == 0, "R9 no read strobe on write", 32'(rd_n), 32'd0);
                chk(lo_n == (split ? int'(be[0]) : 1) && hi_n == (split ? int'(be[1]) : 0),
                    "R9 write strobes", 32'({lo_n[15:0], hi_n[15:0]}),
                    32'({16'(split ? int'(be[0]) : 1), 16'(split ? int'(be[1]) : 0)}));
            end
        end
    endtask

    task automatic print_sum();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        print_sum();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(req_ready && !done && !err && !ale_o && rd_n_o && wr_lo_n_o && wr_hi_n_o
            && addr_oe == '0 && data_oe == '0, "R11 reset quiet", 32'(addr_oe), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 idle after reset", 32'(req_ready), 32'd1);

        // R10 gpio release
        mode_sel = 2'b00; bus8 = 1'b1; #1;
        chk(gpio_free == 16'hFF00, "R10 sep8 gpio", 32'(gpio_free), 32'hFF00);
        mode_sel = 2'b11; bus8 = 1'b0; #1;
        chk(gpio_free == 16'h0000, "R10 sep16 gpio", 32'(gpio_free), 32'h0);
        mode_sel = 2'b01; bus8 = 1'b1; #1;
        chk(gpio_free == 16'hFFFF, "R10 mux8 gpio", 32'(gpio_free), 32'hFFFF);
        mode_sel = 2'b10; bus8 = 1'b0; #1;
        chk(gpio_free == 16'hFFFF, "R10 mux16 gpio", 32'(gpio_free), 32'hFFFF);

        // directed corners
        run_txn(2'b00, 1'b0, 1'b1, 20'h12345, 16'hBEEF, 2'b11);
        run_txn(2'b11, 1'b0, 1'b1, 20'h00002, 16'h1234, 2'b01);
        run_txn(2'b00, 1'b0, 1'b1, 20'h00004, 16'h5678, 2'b10);
        run_txn(2'b00, 1'b0, 1'b1, 20'h00006, 16'h9ABC, 2'b00);
        run_txn(2'b00, 1'b0, 1'b0, 20'hFFFFF, 16'h0000, 2'b11);
        run_txn(2'b11, 1'b1, 1'b0, 20'hABCDE, 16'h0000, 2'b00);
        run_txn(2'b00, 1'b1, 1'b1, 20'h54321, 16'hC3A7, 2'b00);
        run_txn(2'b01, 1'b1, 1'b0, 20'hF0F0F, 16'h0000, 2'b00);
        run_txn(2'b10, 1'b1, 1'b1, 20'h0FF0F, 16'h00E1, 2'b00);
        run_txn(2'b10, 1'b0, 1'b0, 20'hFFFFE, 16'h0000, 2'b00);
        run_txn(2'b01, 1'b0, 1'b1, 20'h80000, 16'hFF5A, 2'b11);
        run_txn(2'b01, 1'b0, 1'b0, 20'h00001, 16'h0000, 2'b00);
        run_txn(2'b10, 1'b0, 1'b1, 20'hFFFFF, 16'h1111, 2'b11);

        // constrained random mix
        for (int i = 0; i < 200; i++)
            run_txn(2'($urandom()), 1'($urandom()), 1'($urandom()), AW'($urandom()),
                    DW'($urandom()), 2'($urandom()));

        @(negedge clk);
        chk(req_ready && addr_oe == '0 && data_oe == '0, "R11 idle at end", 32'(addr_oe), 32'd0);
        print_sum();
        $finish;
    end
endmodule